// File: doc/BRIEF.md
# Selectable Partial-Response Channel Convolver

This block stands in for a noiseless binary-input partial-response channel in hardware-in-the-loop setups. It takes 4-bit symbols over GF(16) through a valid/ready handshake. It breaks each symbol into bits, most significant bit first. Each bit becomes an antipodal level. The block then convolves the level stream with one of three integer impulse responses and emits one signed sample per bit.

The response is chosen by a 2-bit select input. The block reads that input only when it takes a symbol, so the response can change between symbols without corrupting a symbol already in flight. A register of past levels carries the channel memory from one symbol to the next, across response changes as well. A synchronous clear drops any partly sent symbol and fills that register with -1 levels. Its output can feed a detector bench or be compared against a software channel model.

Top module: `pr_chan_conv`

## Requirements
- R1: A symbol is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when no symbol is being sent, and during the cycle that sends the last bit of the current symbol. It is low in the other three bit cycles.
- R2: The bits of a symbol are sent in the order bit 3, bit 2, bit 1, bit 0. A bit of 1 becomes level +1 and a bit of 0 becomes level -1.
- R3: With select code 0 the response is 1 + D²: the sample is x[n] + x[n-2], where x[n] is the level of the current bit.
- R4: With select code 1 the response is 1 + D - D² - D³: the sample is x[n] + x[n-1] - x[n-2] - x[n-3].
- R5: With select code 2 the response is 1 + 2D - 2D³ - D⁴: the sample is x[n] + 2x[n-1] - 2x[n-3] - x[n-4]. Select code 3 behaves like code 0. Every sample lies in -6..+6 and is given in 4-bit two's complement.
- R6: A symbol taken on edge E yields four samples with `out_valid` high, after edges E+1, E+2, E+3 and E+4. `out_valid` is low when no sample is produced.
- R7: After reset or clear, all past levels read as -1. Past levels run on from one symbol to the next, even when the response changes.
- R8: The select value is captured only when a symbol is taken. Changes to `mode_sel` at any other time have no effect on the samples of the symbol being sent.
- R9: When `clr` is high at an edge, the symbol being sent is dropped. After that edge `out_valid` is low, `in_ready` is high and the past levels are all -1.
- R10: If a new symbol is offered during the last bit cycle of the current one, it is taken at once. The sample stream then has no gap between the two symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the symbol in flight and the channel memory |
| in_valid | input | 1 | A symbol is offered |
| in_ready | output | 1 | The block can take a symbol |
| in_sym | input | 4 | Offered symbol |
| mode_sel | input | 2 | Response select: 0 = 1+D², 1 = 1+D-D²-D³, 2 = 1+2D-2D³-D⁴, 3 = same as 0 |
| out_valid | output | 1 | A sample is present |
| out_sample | output | 4 | Signed noiseless channel sample |

## Verification
Two events can land in the same cycle. One is the last bit of a symbol being sent. The other is the next symbol being taken together with its own response select. The bench provokes this with bursts in which each symbol uses a different response. A scoreboard checks every sample against a software model of the channel, and the bench also fails any cycle without a sample while samples are still expected. A second overlap is a clear that arrives while a symbol is in flight. The bench judges it by the missing samples and by the response to the next symbol, which must start from an all -1 history.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int SYM_W   = 4;
    localparam int MEM_MAX = 4;
    localparam int SAMP_W  = 4;
    localparam int ACC_W   = SAMP_W + 2;
    localparam int IDX_W   = $clog2(SYM_W);
    localparam int TAP_W   = 3;
    localparam int PEAK    = 6;

    typedef enum logic [1:0] {
        RESP_P2  = 2'd0,
        RESP_E3  = 2'd1,
        RESP_E4  = 2'd2,
        RESP_ALT = 2'd3
    } resp_e;

    typedef logic signed [TAP_W-1:0] tap_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic  vld;
        logic  lvl_pos;
        resp_e mode;
    } bit_beat_t;

    function automatic tap_t tap_of(input resp_e m, input int k);
        tap_t t;
        t = '0;
        case (m)
            RESP_E3: begin
                case (k)
                    0, 1:    t = 3'sd1;
                    2, 3:    t = -3'sd1;
                    default: t = '0;
                endcase
            end
            RESP_E4: begin
                case (k)
                    0:       t = 3'sd1;
                    1:       t = 3'sd2;
                    3:       t = -3'sd2;
                    4:       t = -3'sd1;
                    default: t = '0;
                endcase
            end
            default: begin
                case (k)
                    0, 2:    t = 3'sd1;
                    default: t = '0;
                endcase
            end
        endcase
        return t;
    endfunction

    function automatic acc_t signed_term(input tap_t t, input logic pos);
        acc_t w;
        w = acc_t'(t);
        return pos ? w : -w;
    endfunction

endpackage

// File: rtl/prc_serializer.sv
module prc_serializer
    import prc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_sym,
    input  resp_e            mode_in,
    output bit_beat_t        beat
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_W - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [SYM_W-1:0] sreg_q;
    resp_e            mode_q;
    logic             last_bit;
    logic             take;

    assign last_bit = busy_q && (idx_q == LAST_IDX);
    assign in_ready = !busy_q || last_bit;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            sreg_q <= '0;
            mode_q <= RESP_P2;
        end else if (take) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            sreg_q <= in_sym;
            mode_q <= mode_in;
        end else if (busy_q) begin
            sreg_q <= {sreg_q[SYM_W-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
            if (last_bit) busy_q <= 1'b0;
        end
    end

    always_comb begin
        beat.vld     = busy_q;
        beat.lvl_pos = sreg_q[SYM_W-1];
        beat.mode    = mode_q;
    end

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> in_ready);

    p_mode_held_r8: assert property (@(posedge clk) disable iff (rst || clr)
        (busy_q && !take) |=> (mode_q == $past(mode_q)));

    p_no_bubble_r10: assert property (@(posedge clk) disable iff (rst || clr)
        (last_bit && in_valid) |=> (busy_q && idx_q == '0));

endmodule

// File: rtl/prc_fir.sv
module prc_fir
    import prc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  bit_beat_t                beat,
    output logic                     out_valid,
    output logic signed [SAMP_W-1:0] out_sample
);

    logic [MEM_MAX-1:0] hist_q;
    logic [MEM_MAX:0]   taps_in;
    acc_t               terms [0:MEM_MAX];
    acc_t               sum;

    assign taps_in = {hist_q, beat.lvl_pos};

    genvar g;
    generate
        for (g = 0; g <= MEM_MAX; g++) begin : g_term
            assign terms[g] = signed_term(tap_of(beat.mode, g), taps_in[g]);
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int k = 0; k <= MEM_MAX; k++) sum = sum + terms[k];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q     <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= beat.vld;
            if (beat.vld) begin
                hist_q     <= {hist_q[MEM_MAX-2:0], beat.lvl_pos};
                out_sample <= sum[SAMP_W-1:0];
            end
        end
    end

    p_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sample >= -SAMP_W'(PEAK) && out_sample <= SAMP_W'(PEAK)));

    p_clear_hist_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hist_q == '0 && !out_valid));

    p_one_per_bit_r6: assert property (@(posedge clk) disable iff (rst || clr)
        beat.vld |=> out_valid);

endmodule

// File: rtl/pr_chan_conv.sv
module pr_chan_conv
    import prc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [SYM_W-1:0]         in_sym,
    input  logic [1:0]               mode_sel,
    output logic                     out_valid,
    output logic signed [SAMP_W-1:0] out_sample
);

    bit_beat_t beat;

    prc_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_sym   (in_sym),
        .mode_in  (resp_e'(mode_sel)),
        .beat     (beat)
    );

    prc_fir u_fir (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .beat       (beat),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    p_clear_ready_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (in_ready && !out_valid));

endmodule

// File: tb/pr_chan_conv_tb_top.sv
module pr_chan_conv_tb_top;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [3:0]        in_sym = '0;
    logic [1:0]        mode_sel = '0;
    logic              out_valid;
    logic signed [3:0] out_sample;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    logic [3:0] m_hist = '0;
    bit burst_on = 0;
    bit burst_seen = 0;

    always #4 clk = ~clk;

    pr_chan_conv dut_i (
        .clk(clk), .rst(rst), .clr(clr),
        .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .mode_sel(mode_sel), .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int tap(input logic [1:0] m, input int k);
        int t[5];
        case (m)
            2'd1:    t = '{1, 1, -1, -1, 0};
            2'd2:    t = '{1, 2, 0, -2, -1};
            default: t = '{1, 0, 1, 0, 0};
        endcase
        return t[k];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_push(input logic [3:0] s, input logic [1:0] m);
        for (int i = 3; i >= 0; i--) begin
            int lv[5];
            int y = 0;
            lv[0] = s[i] ? 1 : -1;
            for (int k = 1; k < 5; k++) lv[k] = m_hist[k-1] ? 1 : -1;
            for (int k = 0; k < 5; k++) y += tap(m, k) * lv[k];
            exp_q.push_back(y);
            m_hist = {m_hist[2:0], s[i]};
        end
    endtask

    // drive at a negedge; returns at the negedge after the accepting edge
    task automatic send(input logic [3:0] s, input logic [1:0] m);
        bit acc = 0;
        in_valid = 1'b1; in_sym = s; mode_sel = m;
        while (!acc) begin
            #1 acc = in_ready;
            @(posedge clk);
        end
        model_push(s, m);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // scoreboard monitor: R2 R3 R4 R5 R6 R7
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) check("R6 unexpected sample", 1, 0);
                else check("R2/R3/R4/R5/R7 sample", int'(out_sample), exp_q.pop_front());
                if (burst_on) burst_seen = 1;
            end else if (burst_on && burst_seen && exp_q.size() != 0) begin
                check("R10 gap in stream", 0, 1);
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        check("watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] lf = 8'h5B;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 ready after reset", int'(in_ready), 1);
        check("R6 no valid after reset", int'(out_valid), 0);
        idle(1);

        // R7: history -1 after reset; R4 response
        send(4'hF, 2'd1);
        check("R1 ready low bit1", int'(in_ready), 0);
        idle(1); check("R1 ready low bit2", int'(in_ready), 0);
        idle(1); check("R1 ready low bit3", int'(in_ready), 0);
        idle(1); check("R1 ready high on last bit", int'(in_ready), 1);
        idle(3);

        // R3, R5, R10: back-to-back across responses
        burst_on = 1; burst_seen = 0;
        send(4'hA, 2'd0);
        send(4'h5, 2'd2);
        send(4'h3, 2'd3);
        send(4'hC, 2'd1);
        idle(6);
        burst_on = 0;
        check("R6 all samples out", exp_q.size(), 0);

        // R8: select changes mid-symbol are ignored
        send(4'h9, 2'd1);
        mode_sel = 2'd2; idle(1);
        mode_sel = 2'd0; idle(1);
        mode_sel = 2'd3; idle(4);
        check("R8 samples drained", exp_q.size(), 0);

        // R9: clear during a symbol
        send(4'hC, 2'd2);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_q.delete();
        m_hist = '0;
        check("R9 no valid after clear", int'(out_valid), 0);
        check("R9 ready after clear", int'(in_ready), 1);
        idle(2);
        check("R9 nothing after clear", int'(out_valid), 0);
        send(4'h6, 2'd2);
        idle(5);

        // mixed burst
        burst_on = 1; burst_seen = 0;
        for (int i = 0; i < 24; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            send(lf[3:0], lf[5:4]);
        end
        idle(6);
        burst_on = 0;
        check("R6 burst drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule